// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a small serial EEPROM. It answers a three-wire serial master through a chip select, a serial clock, a serial data input and a data output that has its own output enable. Each frame opens with a start bit and a two-bit opcode, then an address, and for write-type commands a data word. Seven commands are decoded: read, write and erase of one location, plus four extended commands carried under opcode 00 (write enable, write disable, erase all, write all).

The storage is 1024 bits. A static organisation input chooses how it is seen: as 64 words of 16 bits, or as 128 bytes of 8 bits. Every modifying command is locked out until write enable is given. An accepted modification starts a self-timed program window that is counted in system clocks. While that window runs, the data output gives ready or busy status whenever the chip is selected. The serial pins are brought into the system clock domain through synchronisers, and the block acts on edges detected in that domain.

Top module: `mw_eeprom`

## Requirements
- R1: A frame is a start bit of 1, then a 2-bit opcode (10 read, 01 write, 11 erase, 00 extended), then the address MSB first, then any data MSB first. All of these bits are sampled on rising edges of the serial clock while chip select is high.
- R2: With the organisation input high, the address is 6 bits and the data 16 bits. With it low, the address is 7 bits and the data 8 bits. Word w holds byte 2w in its upper half and byte 2w+1 in its lower half.
- R3: On a read, the output is enabled and drives a 0 after the rising edge that carries the last address bit. Each later rising edge then presents the next data bit, MSB first; in byte mode the byte sits in the low 8 bits of the returned value.
- R4: The output enable is low after reset, whenever chip select is low, and at all times except during read data and status reporting.
- R5: After reset the write-enable latch is clear. Write, erase, erase-all and write-all then have no effect until an extended command with top address bits 11 is received. Top address bits 00 clear the latch again.
- R6: After reset, and after an erase, every bit of the target reads as 1. The extended command with top address bits 10 erases the whole array.
- R7: The extended command with top address bits 01, followed by a data word, writes that word to every location.
- R8: An accepted modifying command starts a program window of PROG_CYCLES system clocks when chip select falls after a complete frame. While chip select is high, the output then shows 0 while the window runs and 1 once it has ended. Start bits are not accepted while the window runs.
- R9: Clocking a 1 into the data input while status is shown drops the output enable after the next falling serial clock edge.
- R10: Dropping chip select before a frame is complete discards it. No location changes and no program window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mw_cs_i | input | 1 | Chip select, active high |
| mw_clk_i | input | 1 | Serial clock from the master |
| mw_di_i | input | 1 | Serial data into the slave |
| org_wide_i | input | 1 | Organisation: 1 selects 16-bit words, 0 selects bytes |
| mw_do_o | output | 1 | Serial data or status out |
| mw_do_oe_o | output | 1 | Output enable for mw_do_o (0 = high impedance) |

## Verification
Every serial edge reaches the controller about three system clocks late: two synchroniser flops plus the edge-detect register. A bit that is shifted out, or a change of enable, therefore appears about three clocks after the serial edge that causes it. The bench holds each serial clock level for six system clocks and samples the outputs only at the end of a low phase, when every due result has settled. The program window begins about three clocks after chip select falls. The bench widens the window to 64 clocks, samples busy about ten clocks into it, and samples ready well after it has expired.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_DONE, ST_RD
  } mw_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WRITE, CMD_ERASE, CMD_ERAL, CMD_WRAL, CMD_EWEN, CMD_EWDS
  } mw_cmd_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] EXT_EWEN  = 2'b11;
  localparam logic [1:0] EXT_EWDS  = 2'b00;
  localparam logic [1:0] EXT_ERAL  = 2'b10;
  localparam logic [1:0] EXT_WRAL  = 2'b01;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int E      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [E-1:0] rise,
  output logic [E-1:0] fall
);
  logic [W-1:0] chain [STAGES];
  logic [E-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      last_q <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last_q <= chain[STAGES-1][W-1 -: E];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q[W-1 -: E] & ~last_q;
  assign fall = ~q[W-1 -: E] & last_q;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ABW = 7,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic           fill,
  input  logic           wide,
  input  logic [ABW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  localparam int NBYTES = 1 << ABW;
  localparam int HW     = DW / 2;

  logic [HW-1:0]  mem [NBYTES];
  logic [ABW-1:0] hi_idx, lo_idx;

  assign hi_idx = {addr[ABW-2:0], 1'b0};
  assign lo_idx = {addr[ABW-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '1;
    end else if (fill) begin
      for (int i = 0; i < NBYTES; i++)
        mem[i] <= (wide && (i % 2 == 0)) ? wdata[DW-1:HW] : wdata[HW-1:0];
    end else if (we) begin
      if (wide) begin
        mem[hi_idx] <= wdata[DW-1:HW];
        mem[lo_idx] <= wdata[HW-1:0];
      end else begin
        mem[addr] <= wdata[HW-1:0];
      end
    end
  end

  assign rdata = wide ? {mem[hi_idx], mem[lo_idx]} : {{HW{1'b0}}, mem[addr]};

  // R7
  wral_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && wide) |=> (mem[0] == $past(wdata[DW-1:HW]) && mem[1] == $past(wdata[HW-1:0])));
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ABW         = 7,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs,
  input  logic           cs_rise,
  input  logic           cs_fall,
  input  logic           sk_rise,
  input  logic           sk_fall,
  input  logic           di,
  input  logic           wide,
  input  logic [DW-1:0]  rdata,
  output logic           arr_we,
  output logic           arr_fill,
  output logic [ABW-1:0] arr_addr,
  output logic [DW-1:0]  arr_wdata,
  output logic           sdo,
  output logic           sdo_oe
);
  localparam int CW = $clog2(DW + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam int HW = DW / 2;

  mw_state_e      st_q, st_d;
  mw_cmd_e        cmd_q, cmd_d;
  logic [CW-1:0]  bit_q, bit_d;
  logic [1:0]     opc_q, opc_d;
  logic [ABW-1:0] adr_q, adr_d, a_sh;
  logic [DW-1:0]  dat_q, dat_d, rsh_q, rsh_d;
  logic [PW-1:0]  prog_q, prog_d;
  logic           wen_q, wen_d, stat_q, stat_d, clr_q, clr_d, sdo_q, sdo_d;
  logic           busy, rd_start;
  logic [CW-1:0]  aw_len, dw_len;
  logic [1:0]     ext;

  assign busy   = (prog_q != '0);
  assign a_sh   = {adr_q[ABW-2:0], di};
  assign aw_len = wide ? CW'(ABW - 1) : CW'(ABW);
  assign dw_len = wide ? CW'(DW) : CW'(HW);
  assign ext    = wide ? a_sh[ABW-2 -: 2] : a_sh[ABW-1 -: 2];

  assign arr_addr  = (st_q == ST_ADR) ? a_sh : adr_q;
  assign arr_wdata = (cmd_q == CMD_ERASE || cmd_q == CMD_ERAL) ? '1 : dat_q;

  always_comb begin
    st_d = st_q; cmd_d = cmd_q; bit_d = bit_q; opc_d = opc_q; adr_d = adr_q;
    dat_d = dat_q; rsh_d = rsh_q; wen_d = wen_q; stat_d = stat_q; clr_d = clr_q;
    sdo_d = sdo_q; arr_we = 1'b0; arr_fill = 1'b0; rd_start = 1'b0;
    prog_d = busy ? prog_q - PW'(1) : prog_q;

    if (sk_fall && clr_q) begin
      stat_d = 1'b0;
      clr_d  = 1'b0;
    end
    if (sk_rise && cs && stat_q && di) clr_d = 1'b1;

    if (cs_fall) begin
      if (st_q == ST_DONE) begin
        unique case (cmd_q)
          CMD_EWEN: wen_d = 1'b1;
          CMD_EWDS: wen_d = 1'b0;
          CMD_WRITE, CMD_ERASE, CMD_ERAL, CMD_WRAL: begin
            if (wen_q) begin
              arr_we   = (cmd_q == CMD_WRITE) || (cmd_q == CMD_ERASE);
              arr_fill = (cmd_q == CMD_ERAL) || (cmd_q == CMD_WRAL);
              prog_d   = PW'(PROG_CYCLES);
              stat_d   = 1'b1;
              clr_d    = 1'b0;
            end
          end
          default: ;
        endcase
      end
      st_d = ST_IDLE;
    end else if (cs_rise) begin
      st_d = ST_IDLE;
    end else if (sk_rise && cs) begin
      unique case (st_q)
        ST_IDLE: if (di && !busy) begin
          st_d = ST_OPC; bit_d = '0; adr_d = '0; dat_d = '0; cmd_d = CMD_NONE;
        end
        ST_OPC: begin
          opc_d = {opc_q[0], di};
          if (bit_q == CW'(1)) begin st_d = ST_ADR; bit_d = '0; end
          else bit_d = bit_q + CW'(1);
        end
        ST_ADR: begin
          adr_d = a_sh;
          bit_d = bit_q + CW'(1);
          if (bit_q == aw_len - CW'(1)) begin
            bit_d = '0;
            unique case (opc_q)
              OPC_READ: begin
                st_d = ST_RD; rd_start = 1'b1; sdo_d = 1'b0;
                rsh_d = wide ? rdata : {rdata[HW-1:0], {HW{1'b0}}};
              end
              OPC_WRITE: begin cmd_d = CMD_WRITE; st_d = ST_DAT; end
              OPC_ERASE: begin cmd_d = CMD_ERASE; st_d = ST_DONE; end
              default: unique case (ext)
                EXT_EWEN: begin cmd_d = CMD_EWEN; st_d = ST_DONE; end
                EXT_EWDS: begin cmd_d = CMD_EWDS; st_d = ST_DONE; end
                EXT_ERAL: begin cmd_d = CMD_ERAL; st_d = ST_DONE; end
                default:  begin cmd_d = CMD_WRAL; st_d = ST_DAT; end
              endcase
            endcase
          end
        end
        ST_DAT: begin
          dat_d = {dat_q[DW-2:0], di};
          if (bit_q == dw_len - CW'(1)) st_d = ST_DONE;
          else bit_d = bit_q + CW'(1);
        end
        ST_RD: begin
          sdo_d = rsh_q[DW-1];
          rsh_d = {rsh_q[DW-2:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cmd_q <= CMD_NONE; bit_q <= '0; opc_q <= '0; adr_q <= '0;
      dat_q <= '0; rsh_q <= '0; prog_q <= '0; wen_q <= 1'b0; stat_q <= 1'b0;
      clr_q <= 1'b0; sdo_q <= 1'b0;
    end else begin
      st_q <= st_d; cmd_q <= cmd_d; bit_q <= bit_d; opc_q <= opc_d; adr_q <= adr_d;
      dat_q <= dat_d; rsh_q <= rsh_d; prog_q <= prog_d; wen_q <= wen_d; stat_q <= stat_d;
      clr_q <= clr_d; sdo_q <= sdo_d;
    end
  end

  assign sdo_oe = cs && ((st_q == ST_RD) || stat_q);
  assign sdo    = (st_q == ST_RD) ? sdo_q : !busy;

  // R5
  locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || arr_fill) |-> wen_q);
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && st_q != ST_DONE) |-> !(arr_we || arr_fill));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(arr_we || arr_fill));
  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> $past(sk_fall));
  // R3
  dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (!cs || (sdo_oe && !sdo)));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mw_cs_i,
  input  logic mw_clk_i,
  input  logic mw_di_i,
  input  logic org_wide_i,
  output logic mw_do_o,
  output logic mw_do_oe_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic [2:0]        pins_s;
  logic [1:0]        rise, fall;
  logic              arr_we, arr_fill;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // bit order: serial clock, chip select, data (edges on the top two)
  mw_sync #(.W(3), .E(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d({mw_clk_i, mw_cs_i, mw_di_i}),
    .q(pins_s), .rise(rise), .fall(fall)
  );

  mw_ctrl #(.ABW(ADDR_W), .DW(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .cs(pins_s[1]), .cs_rise(rise[0]), .cs_fall(fall[0]),
    .sk_rise(rise[1]), .sk_fall(fall[1]), .di(pins_s[0]), .wide(org_wide_i),
    .rdata(arr_rdata), .arr_we(arr_we), .arr_fill(arr_fill), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .sdo(mw_do_o), .sdo_oe(mw_do_oe_o)
  );

  mw_array #(.ABW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_sn), .we(arr_we), .fill(arr_fill), .wide(org_wide_i),
    .addr(arr_addr), .wdata(arr_wdata), .rdata(arr_rdata)
  );

  // R4
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !pins_s[1] |-> !mw_do_oe_o);
endmodule

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int PROG       = 64;

  typedef struct packed {
    logic        wide;
    logic        wr;
    logic [6:0]  adr;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b1, 7'd5,   16'h1234, 16'h1234},
    '{1'b1, 1'b1, 7'd63,  16'hBEEF, 16'hBEEF},
    '{1'b1, 1'b1, 7'd0,   16'h0F0F, 16'h0F0F},
    '{1'b0, 1'b0, 7'd10,  16'h0000, 16'h0012},
    '{1'b0, 1'b0, 7'd11,  16'h0000, 16'h0034},
    '{1'b0, 1'b1, 7'd127, 16'h00A5, 16'h00A5},
    '{1'b1, 1'b0, 7'd63,  16'h0000, 16'hBEA5},
    '{1'b0, 1'b1, 7'd0,   16'h0077, 16'h0077},
    '{1'b1, 1'b0, 7'd0,   16'h0000, 16'h770F}
  };

  logic clk = 1'b0;
  logic rst_n, cs, sk, di, org;
  logic dout, doe;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .mw_cs_i(cs), .mw_clk_i(sk), .mw_di_i(di),
    .org_wide_i(org), .mw_do_o(dout), .mw_do_oe_o(doe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic v);
    di = v; wait_clk(HALF);
    sk = 1'b1; wait_clk(HALF);
    sk = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_on();  cs = 1'b1; wait_clk(HALF); endtask
  task automatic cs_off(); sk = 1'b0; cs = 1'b0; wait_clk(HALF); endtask

  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int dwn(); return org ? 16 : 8; endfunction
  function automatic logic [6:0] ext_adr(input logic [1:0] e);
    return org ? {1'b0, e, 4'b0} : {e, 5'b0};
  endfunction

  task automatic frame(input logic [1:0] opc, input logic [6:0] a,
                       input logic [15:0] d, input bit with_data, input bit keep);
    cs_on();
    pulse(1'b1); pulse(opc[1]); pulse(opc[0]);
    for (int i = aw() - 1; i >= 0; i--) pulse(a[i]);
    if (with_data) for (int i = dwn() - 1; i >= 0; i--) pulse(d[i]);
    if (!keep) cs_off();
  endtask

  task automatic read_word(input logic [6:0] a, output logic [15:0] v, output logic dummy_ok);
    cs_on();
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    for (int i = aw() - 1; i >= 0; i--) pulse(a[i]);
    dummy_ok = (doe === 1'b1) && (dout === 1'b0);
    v = '0;
    for (int i = 0; i < dwn(); i++) begin
      pulse(1'b0);
      v = {v[14:0], dout};
    end
    cs_off();
  endtask

  task automatic write_wait(input logic [1:0] opc, input logic [6:0] a,
                            input logic [15:0] d, input bit with_data);
    frame(opc, a, d, with_data, 1'b0);
    wait_clk(PROG + 20);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic ok;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R4 reset hi-z", {15'd0, doe}, 16'd0);

    // R6 reset contents all ones, R3 dummy zero
    read_word(7'd5, v, ok);
    check("R6 reset erased", v, 16'hFFFF);
    check("R3 dummy bit", {15'd0, ok}, 16'd1);

    // R5 locked write ignored, no status
    frame(2'b01, 7'd5, 16'h1234, 1'b1, 1'b0);
    wait_clk(PROG + 20);
    cs_on();
    check("R5 locked no status", {15'd0, doe}, 16'd0);
    cs_off();
    read_word(7'd5, v, ok);
    check("R5 locked write", v, 16'hFFFF);

    frame(2'b00, ext_adr(2'b11), 16'h0, 1'b0, 1'b0);

    // R1 R2 table of round trips
    foreach (VECS[k]) begin
      org = VECS[k].wide;
      wait_clk(2);
      if (VECS[k].wr) write_wait(2'b01, VECS[k].adr, VECS[k].data, 1'b1);
      read_word(VECS[k].adr, v, ok);
      check(VECS[k].wide ? "R1 word round trip" : "R2 byte view", v, VECS[k].exp);
    end
    org = 1'b1;
    wait_clk(2);

    // R8 busy then R9 clear while busy
    frame(2'b01, 7'd7, 16'hCAFE, 1'b1, 1'b0);
    cs_on();
    check("R8 busy oe", {15'd0, doe}, 16'd1);
    check("R8 busy low", {15'd0, dout}, 16'd0);
    pulse(1'b1);
    check("R9 clear while busy", {15'd0, doe}, 16'd0);
    cs_off();
    wait_clk(PROG + 20);
    read_word(7'd7, v, ok);
    check("R1 write data", v, 16'hCAFE);

    // R8 ready then R9 clear
    frame(2'b01, 7'd8, 16'h1111, 1'b1, 1'b0);
    wait_clk(PROG + 20);
    cs_on();
    check("R8 ready high", {14'd0, doe, dout}, 16'd3);
    pulse(1'b1);
    check("R9 clear when ready", {15'd0, doe}, 16'd0);
    cs_off();

    // R6 erase
    write_wait(2'b11, 7'd7, 16'h0, 1'b0);
    read_word(7'd7, v, ok);
    check("R6 erase word", v, 16'hFFFF);
    read_word(7'd8, v, ok);
    check("R6 neighbour kept", v, 16'h1111);

    // R10 abort mid data
    cs_on();
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    for (int i = 5; i >= 0; i--) pulse(i == 3);
    for (int i = 0; i < 8; i++) pulse(1'b0);
    cs_off();
    wait_clk(PROG + 20);
    cs_on();
    check("R10 no program", {15'd0, doe}, 16'd0);
    cs_off();
    read_word(7'd8, v, ok);
    check("R10 abort no effect", v, 16'h1111);

    // R7 write all
    write_wait(2'b00, ext_adr(2'b01), 16'h5A3C, 1'b1);
    read_word(7'd0, v, ok);
    check("R7 wral word 0", v, 16'h5A3C);
    read_word(7'd63, v, ok);
    check("R7 wral word 63", v, 16'h5A3C);
    org = 1'b0; wait_clk(2);
    read_word(7'd1, v, ok);
    check("R7 wral byte 1", v, 16'h003C);
    org = 1'b1; wait_clk(2);

    // R6 erase all
    write_wait(2'b00, ext_adr(2'b10), 16'h0, 1'b0);
    read_word(7'd20, v, ok);
    check("R6 eral", v, 16'hFFFF);

    // R5 disable relocks
    frame(2'b00, ext_adr(2'b00), 16'h0, 1'b0, 1'b0);
    write_wait(2'b01, 7'd3, 16'h0000, 1'b1);
    read_word(7'd3, v, ok);
    check("R5 relocked", v, 16'hFFFF);

    wait_clk(4);
    check("R4 idle hi-z", {15'd0, doe}, 16'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule